// File: doc/BRIEF.md
# MDIO Management Master

This block is a bus master for the two-wire PHY management interface (MDC clock plus bidirectional MDIO data). Host logic reads and writes 16-bit registers inside an external Ethernet PHY through a small register bank. The bank holds a clock-ratio select, a command bit, a PHY/register address, outgoing write data, returned read data and a busy flag.

Each transaction is started by a register write. Storing a value in the write-data register sends a clause-22 write frame. A 0-to-1 change of the command bit sends a read frame. The block divides the system clock down to MDC and shifts the frame out MSB first. On reads it releases MDIO for the turnaround and data phases, then captures the PHY's 16 data bits. Software polls the busy flag and waits until it reads 0 before starting the next operation.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, `mdio_oe` is 0, busy (bit 0 at offset 5) reads 0, read data (offset 4) reads 0 and the ratio select (offset 0) reads 5.
- R2: Register offsets are: 0 for the ratio select in bits 2:0, 1 for the command in bit 0, 2 for the address, 3 for write data, 4 for read data and 5 for the indicator with busy in bit 0. The address register keeps the PHY number in bits 12:8 and the register number in bits 4:0, and reads back what was written.
- R3: A write to offset 3 while idle sends exactly 64 MDC cycles carrying 32 ones, start 01, opcode 01, the 5-bit PHY and register numbers, turnaround 10 and the 16 data bits, MSB first, with MDIO driven throughout.
- R4: A read frame starts only when bit 0 of offset 1 goes from 0 to 1. Writing 1 when the stored bit is already 1 starts nothing.
- R5: A read frame drives 32 ones, 01, opcode 10 and the two addresses (46 bits), then releases MDIO. It samples MDIO at each MDC rising edge of the last 16 bits and places them in offset 4 when busy falls.
- R6: With select value s, MDC has period 2·(s+2) system clocks (s=5 gives divide-by-14). Busy stays 1 for exactly 128·(s+2) cycles after the starting edge, and MDC is low whenever busy is 0.
- R7: Start requests made while busy is 1, including the last busy cycle, are ignored. Changes to the select, address or write data during a frame do not alter that frame, because they are latched at its start.
- R8: While a frame runs, MDIO changes only on the clock edge where MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 16 | Register write value |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 16 | Register read value (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
A frame ends and a new start request can arrive in the same cycle, on the edge where busy drops. The bench times a write-data store to land on that exact edge. It then checks that busy stays 0 and that no further MDC edges appear. A second store one cycle later must start a frame. The same kind of collision is provoked mid-frame with select, address, data and command writes. Each is judged by comparing the captured frame and the busy length against values computed from the original settings.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SEL_RST = 5,
  parameter int PRE_LEN = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int FL = PRE_LEN + 32;
  localparam int BW = $clog2(FL);
  localparam int HW = SEL_W + 1;
  localparam int DRV_RD = PRE_LEN + 14;
  localparam int RX_FIRST = PRE_LEN + 16;
  localparam logic [2:0] OFF_CFG = 3'd0, OFF_CMD = 3'd1, OFF_ADR = 3'd2,
                         OFF_CTL = 3'd3, OFF_STA = 3'd4, OFF_IND = 3'd5;

  logic [SEL_W-1:0] sel_q;
  logic             cmd_q;
  logic [4:0]       phy_q, reg_q;
  logic [DW-1:0]    status_q, rx_q;
  logic             busy_q, rd_q, mdc_q;
  logic [HW-1:0]    half_q, hcnt_q;
  logic [BW-1:0]    bit_q;
  logic [FL-1:0]    frame_q;

  wire start_wr = wr_en && wr_addr == OFF_CTL && !busy_q;
  wire start_rd = wr_en && wr_addr == OFF_CMD && wr_data[0] && !cmd_q && !busy_q;
  wire phase_end = hcnt_q == half_q - HW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
      cmd_q <= 1'b0;
      phy_q <= '0;
      reg_q <= '0;
      status_q <= '0;
      rx_q <= '0;
      busy_q <= 1'b0;
      rd_q <= 1'b0;
      mdc_q <= 1'b0;
      half_q <= HW'(2);
      hcnt_q <= '0;
      bit_q <= '0;
      frame_q <= '0;
    end else begin
      if (wr_en && wr_addr == OFF_CFG) sel_q <= wr_data[SEL_W-1:0];
      if (wr_en && wr_addr == OFF_CMD) cmd_q <= wr_data[0];
      if (wr_en && wr_addr == OFF_ADR) begin
        phy_q <= wr_data[12:8];
        reg_q <= wr_data[4:0];
      end
      if (start_wr || start_rd) begin
        busy_q <= 1'b1;
        rd_q <= start_rd;
        half_q <= HW'(sel_q) + HW'(2);
        hcnt_q <= '0;
        bit_q <= '0;
        mdc_q <= 1'b0;
        frame_q <= {{PRE_LEN{1'b1}}, 2'b01, start_rd ? 2'b10 : 2'b01, phy_q, reg_q,
                    2'b10, start_rd ? 16'h0 : wr_data[15:0]};
      end else if (busy_q) begin
        if (phase_end) begin
          hcnt_q <= '0;
          mdc_q <= ~mdc_q;
          if (!mdc_q) begin
            if (rd_q && bit_q >= BW'(RX_FIRST)) rx_q <= {rx_q[DW-2:0], mdio_i};
          end else if (bit_q == BW'(FL - 1)) begin
            busy_q <= 1'b0;
            if (rd_q) status_q <= rx_q;
          end else begin
            bit_q <= bit_q + BW'(1);
            frame_q <= {frame_q[FL-2:0], 1'b0};
          end
        end else begin
          hcnt_q <= hcnt_q + HW'(1);
        end
      end
    end
  end

  assign mdc = mdc_q;
  assign mdio_o = busy_q ? frame_q[FL-1] : 1'b1;
  assign mdio_oe = busy_q && (!rd_q || bit_q < BW'(DRV_RD));

  always_comb begin
    case (rd_addr)
      OFF_CFG: rd_data = DW'(sel_q);
      OFF_CMD: rd_data = DW'(cmd_q);
      OFF_ADR: rd_data = {3'b000, phy_q, 3'b000, reg_q};
      OFF_STA: rd_data = status_q;
      OFF_IND: rd_data = DW'(busy_q);
      default: rd_data = '0;
    endcase
  end
endmodule

module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       wr_en,
  input logic [2:0] wr_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  a_r6_mdc_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(busy));
  a_r6_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));
  a_r8_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
  a_r5_oe_rises_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $rose(busy));
  a_r7_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && (wr_addr == 3'd3 || wr_addr == 3'd1)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, mdio_i = 1;
  logic [2:0] wr_addr = 0, rd_addr = 5;
  logic [15:0] wr_data = 0, rd_data;
  logic mdc, mdio_o, mdio_oe;
  int total = 0, bad = 0;
  int nb = 0, oecnt = 0, n_busy = 0, n_high = 0;
  logic [63:0] cap = 0;
  logic [15:0] rdv = 0;

  mdio_master u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2 clk = ~clk;

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_o};
    oecnt = oecnt + (mdio_oe ? 1 : 0);
    nb = nb + 1;
  end
  always @(negedge mdc) mdio_i = (nb >= 48 && nb < 64) ? rdv[63-nb] : 1'b1;

  function automatic logic [63:0] wframe(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction
  function automatic logic [45:0] rhdr(logic [4:0] p, logic [4:0] r);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #0.5 v = rd_data;
    rd_addr = 5;
  endtask

  task automatic phy_clr();
    nb = 0; oecnt = 0; cap = 0;
  endtask

  task automatic wait_done();
    logic [15:0] v;
    n_busy = 0; n_high = 0;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      rd(3'd5, v);
      if (!v[0]) break;
      n_busy++;
      if (mdc) n_high++;
    end
  endtask

  task automatic do_write(input int s, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    wr(3'd0, 16'(s));
    wr(3'd2, {3'b0, p, 3'b0, r});
    phy_clr();
    wr(3'd3, d);
    wait_done();
    chk(cap == wframe(p, r, d), "R3 write frame", cap, wframe(p, r, d));
    chk(oecnt == 64 && nb == 64, "R3 driven bits", 64'(oecnt), 64);
    chk(n_busy == 128 * (s + 2), "R6 busy length", 64'(n_busy), 64'(128 * (s + 2)));
    chk(n_high == 64 * (s + 2), "R6 mdc high time", 64'(n_high), 64'(64 * (s + 2)));
  endtask

  task automatic do_read(input int s, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [15:0] v;
    wr(3'd0, 16'(s));
    wr(3'd2, {3'b0, p, 3'b0, r});
    wr(3'd1, 16'h0);
    rdv = d;
    phy_clr();
    wr(3'd1, 16'h1);
    wait_done();
    rd(3'd4, v);
    chk(v == d, "R5 read data", 64'(v), 64'(d));
    chk(cap[63:18] == rhdr(p, r), "R5 read header", 64'(cap[63:18]), 64'(rhdr(p, r)));
    chk(oecnt == 46, "R5 release point", 64'(oecnt), 46);
    chk(n_busy == 128 * (s + 2), "R6 read busy length", 64'(n_busy), 64'(128 * (s + 2)));
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe, "R1 pins idle", {62'b0, mdc, mdio_oe}, 0);
    rd(3'd5, v); chk(v == 0, "R1 busy", 64'(v), 0);
    rd(3'd4, v); chk(v == 0, "R1 status", 64'(v), 0);
    rd(3'd0, v); chk(v == 5, "R1 select", 64'(v), 5);
    rst_n = 1;

    do_write(5, 5'h11, 5'h04, 16'h01E1);
    rd(3'd2, v); chk(v == 16'h1104, "R2 address readback", 64'(v), 16'h1104);
    do_read(5, 5'h02, 5'h01, 16'h796D);

    // R4: command already 1, setting again does nothing
    phy_clr();
    wr(3'd1, 16'h1);
    repeat (4) @(negedge clk);
    rd(3'd5, v);
    chk(v == 0 && nb == 0, "R4 no relaunch", 64'(v), 0);

    // R7: writes during a frame leave it intact
    wr(3'd0, 16'd1);
    wr(3'd2, 16'h0A15);
    wr(3'd1, 16'h0);
    phy_clr();
    wr(3'd3, 16'hC3A5);
    fork
      wait_done();
      begin
        repeat (40) @(negedge clk);
        wr(3'd3, 16'h1111);
        wr(3'd2, 16'h1F1F);
        wr(3'd0, 16'd3);
        wr(3'd1, 16'h1);
      end
    join
    chk(cap == wframe(5'h0A, 5'h15, 16'hC3A5), "R7 frame unchanged", cap, wframe(5'h0A, 5'h15, 16'hC3A5));
    chk(n_busy == 384, "R7 ratio latched", 64'(n_busy), 384);
    rd(3'd4, v); chk(v == 16'h796D, "R7 status untouched", 64'(v), 16'h796D);
    phy_clr();
    wr(3'd1, 16'h1);
    repeat (4) @(negedge clk);
    rd(3'd5, v); chk(v == 0, "R4 set while busy then set again", 64'(v), 0);

    // R7 boundary: request on the edge where busy drops
    wr(3'd0, 16'd0);
    wr(3'd2, 16'h0307);
    phy_clr();
    wr(3'd3, 16'h5A5A);
    n_busy = 0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      rd(3'd5, v);
      if (v[0]) n_busy++;
      if (n_busy == 256) begin
        wr_en = 1; wr_addr = 3; wr_data = 16'hFFFF;
        @(posedge clk);
        #1 wr_en = 0;
        break;
      end
    end
    repeat (6) @(negedge clk);
    rd(3'd5, v);
    chk(v == 0 && nb == 64, "R7 last-cycle request ignored", {v, 48'(nb)}, 64);
    chk(cap == wframe(5'h03, 5'h07, 16'h5A5A), "R8 frame before boundary", cap, wframe(5'h03, 5'h07, 16'h5A5A));
    do_write(0, 5'h03, 5'h07, 16'hFFFF);

    for (int i = 0; i < 14; i++) begin
      int s = int'($urandom % 4);
      logic [4:0] p = 5'($urandom);
      logic [4:0] r = 5'($urandom);
      logic [15:0] d = 16'($urandom);
      if ($urandom % 2 == 0) do_write(s, p, r, d);
      else do_read(s, p, r, d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule